// File: doc/BRIEF.md
# Privileged Tick Counter with Compare Interrupt

This block keeps a free-running processor tick count next to a compare register that raises a timer interrupt. Software reaches both registers through one read/write port. Every access on that port carries a privilege flag. The count register is CNT_W bits wide. One more bit sits above it, the top bit (bit 63 at the default width). In the count register, that top bit is a trap flag for unprivileged access. In the compare register, the same bit position disables the interrupt. The two meanings are kept strictly apart.

Software arms the interrupt by writing a future count value into the compare register with the top bit clear. When the count reaches that value, a sticky pending bit is set, and it stays set until an acknowledge pulse clears it. An unprivileged read of the count while the trap flag is set returns no data and raises a trap pulse instead. The same design serves as the ordinary tick, the system tick or the hypervisor tick instance, with the width chosen by a parameter.

Top module: `tick_timer`

## Requirements
- R1: After reset the count is zero, the count trap flag (top bit) is 1, and the compare register holds only its top bit set. The outputs irq_o, trap_o and rd_valid_o are 0.
- R2: The count advances by one on each clock edge where cnt_en_i is 1, holds while cnt_en_i is 0, and wraps from all ones to zero. The trap flag is left unchanged by this.
- R3: A privileged write with sel_i=0 loads wdata_i bits CNT_W-1:0 as the count and bit CNT_W as the trap flag. The new value is seen right after that clock edge, and the write takes priority over the increment.
- R4: A privileged read returns the full register, top bit included (sel_i=0 count, sel_i=1 compare), on rdata_o with rd_valid_o=1 one cycle after the read is sampled. A count read returns the value held at the sampling edge.
- R5: When the low CNT_W bits of the count equal those of the compare register and the compare top bit is 0, irq_o goes to 1 one cycle later.
- R6: While the compare top bit is 1, no interrupt is raised, whatever the low bits hold.
- R7: With ZERO_DISARMS=1, a compare register that holds all zeros is disarmed: no interrupt is raised when the count passes zero.
- R8: irq_o stays 1 until ack_i is sampled high, and rewriting the compare register does not clear it. If a match and an acknowledge happen in the same cycle, the match wins.
- R9: An unprivileged count read with the trap flag set gives rd_valid_o=0 and trap_o=1 one cycle later. With the flag clear, the same read returns the count normally.
- R10: Unprivileged writes to either register change nothing and give trap_o=1 one cycle later.
- R11: An unprivileged read of the compare register gives rd_valid_o=0 and trap_o=1 one cycle later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cnt_en_i | input | 1 | Count enable |
| wr_en_i | input | 1 | Register write strobe |
| rd_en_i | input | 1 | Register read strobe |
| sel_i | input | 1 | Register select: 0 count, 1 compare |
| priv_i | input | 1 | Access is privileged |
| wdata_i | input | CNT_W+1 | Write data |
| ack_i | input | 1 | Interrupt acknowledge |
| rdata_o | output | CNT_W+1 | Read data, registered |
| rd_valid_o | output | 1 | Read data valid |
| trap_o | output | 1 | Privilege trap pulse |
| irq_o | output | 1 | Sticky timer interrupt request |

## Verification
The bench builds the block with CNT_W=8, so each register is nine bits wide and the top bit is bit 8. At that width the count wraps every 256 cycles. This puts wrap-around, the pass through zero against a zeroed compare register, and exact match timing within a few cycles of a directed write. The default ZERO_DISARMS=1 is kept, so the zero-disarm behaviour is exercised.

// File: rtl/tick_timer_pkg.sv
package tick_timer_pkg;
  typedef enum logic {
    SEL_COUNT = 1'b0,
    SEL_LIMIT = 1'b1
  } tick_sel_e;
endpackage

// File: rtl/tick_counter.sv
module tick_counter #(
  parameter int CNT_W = 63,
  localparam int DW = CNT_W + 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic             ld_i,
  input  logic [DW-1:0]    ld_data_i,
  output logic [CNT_W-1:0] count_o,
  output logic             npt_o
);
  logic [CNT_W-1:0] count_q;
  logic             npt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      count_q <= '0;
      npt_q   <= 1'b1;
    end else if (ld_i) begin
      count_q <= ld_data_i[CNT_W-1:0];
      npt_q   <= ld_data_i[CNT_W];
    end else if (en_i) begin
      count_q <= count_q + 1'b1;
    end
  end

  assign count_o = count_q;
  assign npt_o   = npt_q;

  // R2
  count_inc_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(rst_ni) && $past(en_i) && !$past(ld_i)) |-> (count_q == $past(count_q) + 1'b1));
  // R2
  count_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(rst_ni) && !$past(en_i) && !$past(ld_i)) |-> $stable(count_q));
  // R3
  count_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(rst_ni) && $past(ld_i)) |-> ({npt_q, count_q} == $past(ld_data_i)));
endmodule

// File: rtl/tick_compare.sv
module tick_compare #(
  parameter int CNT_W        = 63,
  parameter bit ZERO_DISARMS = 1'b1,
  localparam int DW = CNT_W + 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [CNT_W-1:0] count_i,
  input  logic             wr_i,
  input  logic [DW-1:0]    wr_data_i,
  input  logic             ack_i,
  output logic [DW-1:0]    limit_o,
  output logic             pend_o
);
  logic [DW-1:0] limit_q;
  logic          pend_q;
  logic          armed;
  logic          hit;

  generate
    if (ZERO_DISARMS) begin : g_zero_off
      assign armed = !limit_q[CNT_W] && (limit_q[CNT_W-1:0] != '0);
    end else begin : g_zero_live
      assign armed = !limit_q[CNT_W];
    end
  endgenerate

  assign hit = armed && (count_i == limit_q[CNT_W-1:0]);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      limit_q <= {1'b1, {CNT_W{1'b0}}};
      pend_q  <= 1'b0;
    end else begin
      if (wr_i) limit_q <= wr_data_i;
      if (hit)        pend_q <= 1'b1;
      else if (ack_i) pend_q <= 1'b0;
    end
  end

  assign limit_o = limit_q;
  assign pend_o  = pend_q;

  // R5
  pend_match_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(pend_q) |-> ($past(count_i) == $past(limit_q[CNT_W-1:0])));
  // R6
  pend_disabled_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(pend_q) |-> !$past(limit_q[CNT_W]));
  // R8
  pend_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(rst_ni) && $past(pend_q) && !$past(ack_i)) |-> pend_q);
endmodule

// File: rtl/tick_access.sv
module tick_access
  import tick_timer_pkg::*;
#(
  parameter int DW = 64
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_en_i,
  input  logic          rd_en_i,
  input  logic          sel_i,
  input  logic          priv_i,
  input  logic          npt_i,
  input  logic [DW-1:0] count_full_i,
  input  logic [DW-1:0] limit_i,
  output logic          cnt_wr_o,
  output logic          cmp_wr_o,
  output logic [DW-1:0] rdata_o,
  output logic          rd_valid_o,
  output logic          trap_o
);
  tick_sel_e sel;
  logic      rd_ok;
  logic      bad;
  logic [DW-1:0] rdata_q;
  logic          rd_valid_q;
  logic          trap_q;

  assign sel      = tick_sel_e'(sel_i);
  assign cnt_wr_o = wr_en_i && priv_i && (sel == SEL_COUNT);
  assign cmp_wr_o = wr_en_i && priv_i && (sel == SEL_LIMIT);
  // unprivileged: compare never readable, count only with trap flag clear
  assign rd_ok    = rd_en_i && (priv_i || ((sel == SEL_COUNT) && !npt_i));
  assign bad      = (wr_en_i && !priv_i) || (rd_en_i && !rd_ok);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rdata_q    <= '0;
      rd_valid_q <= 1'b0;
      trap_q     <= 1'b0;
    end else begin
      rd_valid_q <= rd_ok;
      trap_q     <= bad;
      if (rd_ok) rdata_q <= (sel == SEL_LIMIT) ? limit_i : count_full_i;
      else       rdata_q <= '0;
    end
  end

  assign rdata_o    = rdata_q;
  assign rd_valid_o = rd_valid_q;
  assign trap_o     = trap_q;

  // R9
  npt_block_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(rst_ni) && $past(rd_en_i && !priv_i && npt_i && !sel_i)) |-> (trap_q && !rd_valid_q));
  // R10
  unpriv_wr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(rst_ni) && $past(wr_en_i && !priv_i)) |-> trap_q);
  // R11
  unpriv_cmp_rd_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(rst_ni) && $past(rd_en_i && !priv_i && sel_i)) |-> (trap_q && !rd_valid_q));
  // R4
  priv_rd_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(rst_ni) && $past(rd_en_i && priv_i)) |-> rd_valid_q);
endmodule

// File: rtl/tick_timer.sv
module tick_timer #(
  parameter int CNT_W        = 63,
  parameter bit ZERO_DISARMS = 1'b1
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           cnt_en_i,
  input  logic           wr_en_i,
  input  logic           rd_en_i,
  input  logic           sel_i,
  input  logic           priv_i,
  input  logic [CNT_W:0] wdata_i,
  input  logic           ack_i,
  output logic [CNT_W:0] rdata_o,
  output logic           rd_valid_o,
  output logic           trap_o,
  output logic           irq_o
);
  localparam int DW = CNT_W + 1;

  logic [CNT_W-1:0] count;
  logic             npt;
  logic [DW-1:0]    limit;
  logic             cnt_wr;
  logic             cmp_wr;

  tick_counter #(.CNT_W(CNT_W)) u_counter (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .en_i      (cnt_en_i),
    .ld_i      (cnt_wr),
    .ld_data_i (wdata_i),
    .count_o   (count),
    .npt_o     (npt)
  );

  tick_compare #(.CNT_W(CNT_W), .ZERO_DISARMS(ZERO_DISARMS)) u_compare (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .count_i   (count),
    .wr_i      (cmp_wr),
    .wr_data_i (wdata_i),
    .ack_i     (ack_i),
    .limit_o   (limit),
    .pend_o    (irq_o)
  );

  tick_access #(.DW(DW)) u_access (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .wr_en_i      (wr_en_i),
    .rd_en_i      (rd_en_i),
    .sel_i        (sel_i),
    .priv_i       (priv_i),
    .npt_i        (npt),
    .count_full_i ({npt, count}),
    .limit_i      (limit),
    .cnt_wr_o     (cnt_wr),
    .cmp_wr_o     (cmp_wr),
    .rdata_o      (rdata_o),
    .rd_valid_o   (rd_valid_o),
    .trap_o       (trap_o)
  );
endmodule

// File: tb/tb_tick_timer.sv
`timescale 1ns/1ps
module tb_tick_timer;
  localparam int CNT_W = 8;
  localparam int DW    = CNT_W + 1;

  logic          clk = 1'b0;
  logic          rst_ni;
  logic          cnt_en_i, wr_en_i, rd_en_i, sel_i, priv_i, ack_i;
  logic [DW-1:0] wdata_i;
  logic [DW-1:0] rdata_o;
  logic          rd_valid_o, trap_o, irq_o;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #4 clk = ~clk;

  tick_timer #(.CNT_W(CNT_W), .ZERO_DISARMS(1'b1)) dut (
    .clk_i(clk), .rst_ni(rst_ni), .cnt_en_i(cnt_en_i), .wr_en_i(wr_en_i),
    .rd_en_i(rd_en_i), .sel_i(sel_i), .priv_i(priv_i), .wdata_i(wdata_i),
    .ack_i(ack_i), .rdata_o(rdata_o), .rd_valid_o(rd_valid_o),
    .trap_o(trap_o), .irq_o(irq_o)
  );

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  // every task starts at a negedge, uses one posedge, returns at the next negedge
  task automatic wr_reg(logic s, logic p, logic [DW-1:0] d);
    wr_en_i = 1'b1; sel_i = s; priv_i = p; wdata_i = d;
    @(posedge clk); @(negedge clk);
    wr_en_i = 1'b0; priv_i = 1'b1;
  endtask

  task automatic rd_reg(logic s, logic p);
    rd_en_i = 1'b1; sel_i = s; priv_i = p;
    @(posedge clk); @(negedge clk);
    rd_en_i = 1'b0; priv_i = 1'b1;
  endtask

  task automatic skip(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic t_reset();
    chk("R1 irq", irq_o, 0);
    chk("R1 trap", trap_o, 0);
    chk("R1 valid", rd_valid_o, 0);
    @(negedge clk); rst_ni = 1'b1;
    rd_reg(1'b1, 1'b1);
    chk("R1 compare reset", rdata_o, 9'h100);
    rd_reg(1'b0, 1'b1);
    chk("R1 trap flag reset", rdata_o[CNT_W], 1);
  endtask

  task automatic t_load_read();
    wr_reg(1'b0, 1'b1, 9'h150);
    rd_reg(1'b0, 1'b1);
    chk("R3 load", rdata_o, 9'h150);
    chk("R4 valid", rd_valid_o, 1);
    rd_reg(1'b0, 1'b1);
    chk("R4 next count", rdata_o, 9'h151);
  endtask

  task automatic t_wrap_enable();
    wr_reg(1'b0, 1'b1, 9'h0FF);
    rd_reg(1'b0, 1'b1); chk("R2 pre-wrap", rdata_o, 9'h0FF);
    rd_reg(1'b0, 1'b1); chk("R2 wrap", rdata_o, 9'h000);
    wr_reg(1'b0, 1'b1, 9'h1FF);
    rd_reg(1'b0, 1'b1); chk("R2 pre-wrap flag", rdata_o, 9'h1FF);
    rd_reg(1'b0, 1'b1); chk("R2 wrap keeps flag", rdata_o, 9'h100);
    cnt_en_i = 1'b0;
    wr_reg(1'b0, 1'b1, 9'h033);
    rd_reg(1'b0, 1'b1); chk("R2 held", rdata_o, 9'h033);
    skip(3);
    rd_reg(1'b0, 1'b1); chk("R2 still held", rdata_o, 9'h033);
    cnt_en_i = 1'b1;
  endtask

  task automatic t_match_sticky();
    wr_reg(1'b0, 1'b1, 9'h010);
    wr_reg(1'b1, 1'b1, 9'h015);
    skip(3); chk("R5 before match", irq_o, 0);
    skip(1); chk("R5 match cycle", irq_o, 0);
    skip(1); chk("R5 raised", irq_o, 1);
    skip(20); chk("R8 sticky", irq_o, 1);
    wr_reg(1'b1, 1'b1, 9'h100);
    chk("R8 compare rewrite keeps irq", irq_o, 1);
    ack_i = 1'b1; @(posedge clk); @(negedge clk); ack_i = 1'b0;
    chk("R8 ack clears", irq_o, 0);
    skip(5); chk("R8 stays clear", irq_o, 0);
  endtask

  task automatic t_disable();
    wr_reg(1'b0, 1'b1, 9'h010);
    wr_reg(1'b1, 1'b1, 9'h115);
    skip(12); chk("R6 disabled no irq", irq_o, 0);
    rd_reg(1'b1, 1'b1); chk("R4 compare full read", rdata_o, 9'h115);
  endtask

  task automatic t_zero();
    wr_reg(1'b0, 1'b1, 9'h0FE);
    wr_reg(1'b1, 1'b1, 9'h000);
    skip(6); chk("R7 zero compare no irq", irq_o, 0);
  endtask

  task automatic t_priv();
    wr_reg(1'b0, 1'b1, 9'h150);
    rd_reg(1'b0, 1'b0);
    chk("R9 blocked valid", rd_valid_o, 0);
    chk("R9 trap", trap_o, 1);
    wr_reg(1'b0, 1'b1, 9'h042);
    chk("R9 trap is pulse", trap_o, 0);
    rd_reg(1'b0, 1'b0);
    chk("R9 allowed valid", rd_valid_o, 1);
    chk("R9 allowed data", rdata_o, 9'h042);
    chk("R9 allowed no trap", trap_o, 0);
    wr_reg(1'b0, 1'b1, 9'h060);
    wr_reg(1'b0, 1'b0, 9'h0AA);
    chk("R10 count write trap", trap_o, 1);
    rd_reg(1'b0, 1'b1); chk("R10 count unchanged", rdata_o, 9'h061);
    wr_reg(1'b1, 1'b1, 9'h120);
    wr_reg(1'b1, 1'b0, 9'h005);
    chk("R10 compare write trap", trap_o, 1);
    rd_reg(1'b1, 1'b1); chk("R10 compare unchanged", rdata_o, 9'h120);
    rd_reg(1'b1, 1'b0);
    chk("R11 compare read trap", trap_o, 1);
    chk("R11 compare read invalid", rd_valid_o, 0);
  endtask

  initial begin
    rst_ni = 1'b0; cnt_en_i = 1'b1; wr_en_i = 1'b0; rd_en_i = 1'b0;
    sel_i = 1'b0; priv_i = 1'b1; ack_i = 1'b0; wdata_i = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    t_reset();
    t_load_read();
    t_wrap_enable();
    t_match_sticky();
    t_disable();
    t_zero();
    t_priv();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule